// File: doc/BRIEF.md
# Multi-Mode Timer with Period and Waveform Channel

This block is a counter of parameterized width, 16 bits by default. It runs in one of four counting modes. An enable input gates each count step, and a power-of-two prescaler divides the steps first. Two channels sit beside the counter. Channel 0 holds the period value used by the up and up/down modes. Channel 1 holds a second value and drives a waveform output. Either channel can instead capture the count on a selected edge of its own input. That input passes through a two-stage synchronizer first.

Software works through a single register port: a write strobe, a read strobe, a shared address, write data and combinational read data. Three flags are visible as outputs: the counter's wrap flag and one flag per channel. Software can set or clear each of them. The waveform output follows eight modes. These combine actions taken when the count reaches the channel 1 value and when it reaches the period value.

Top module: `mode_timer`

## Requirements
- R1: Register map by regAddr. 0 is control: mode [1:0], divide [3:2], clear [4] (reads 0), wrap flag [5]. 1 is the counter. 2 is the channel 0 value (period). 3 is channel 0 control. 4 is the channel 1 value. 5 is channel 1 control. Channel control fields: capture select [0], edge code [2:1], flag [3], capture overflow [4], synchronized input [5] (read only), output mode [8:6] and output bit [9] (both channel 1 only). Unused bits read 0. Reset leaves every register, flag and pwmOut at 0.
- R2: Mode 00 holds the counter whatever clkEn does.
- R3: Mode 01 steps 0,1,..,P,0 with P the period value. The channel 0 flag sets as the count reaches P, and the wrap flag sets on the step from P to 0.
- R4: Mode 10 steps through 0..0xFFFF and wraps. The wrap flag sets on the 0xFFFF to 0 step.
- R5: Mode 11 counts up to P and then back down to 0, repeatedly. The channel 0 flag sets on the step into P, and the wrap flag sets on the 1 to 0 step.
- R6: Divide codes 0..3 give one count step per 1, 2, 4 or 8 clkEn pulses, counted from the last clear.
- R7: Writing 1 to the clear bit zeroes the counter and the prescaler. A counter write loads the written value, so writing 0 also resets the count.
- R8: A period value of 0 halts counting in modes 01 and 11 but not in mode 10.
- R9: In capture mode, edge code 00 captures nothing, 01 captures on rising edges, 10 on falling edges and 11 on both. A capture stores the count in the channel value register and sets the channel flag. The synchronized input level reads back two clocks after the pin changes.
- R10: The capture overflow bit sets when a capture occurs while the previous captured value has not been read (a read of the channel value register with rdEn). Software clears it by writing.
- R11: In compare mode a channel flag sets when the count steps to that channel's value. Software writes set or clear the channel flags (bit 3) and the wrap flag (control bit 5).
- R12: Output mode 0 drives pwmOut from the output bit. Modes 1..7 act on a channel 1 match or a period match: 1 set on match; 2 toggle on match, clear on period; 3 set on match, clear on period; 4 toggle on match; 5 clear on match; 6 toggle on match, set on period; 7 clear on match, set on period.
- R13: When both matches fall in the same step, the channel 1 action is applied first and the period action last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Count enable pulse, feeds the prescaler |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (marks captured values as read) |
| regAddr | input | 3 | Register address for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for regAddr, combinational |
| capIn | input | 2 | Capture inputs, bit i for channel i |
| pwmOut | output | 1 | Waveform output of channel 1 |
| ovfFlag | output | 1 | Counter wrap flag |
| chFlag | output | 2 | Channel flags, bit i for channel i |

## Verification
The assertions assume that the period register changes only through writes and channel 0 captures, and that no write touches the counter or control register in the cycles where a wrap is being checked. Their antecedents exclude those cycles. The stimulus stays within these limits by design. It holds clkEn low during every register write. It leaves the counter halted while capture edges are applied, so the captured value is known. It picks random periods, start values and pulse counts only inside each mode's legal range. The edges of capIn change only at falling clock edges, two or more cycles apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_UP   = 2'b01,
    MODE_FREE = 2'b10,
    MODE_UPDN = 2'b11
  } cntMode_t;

  typedef struct packed {
    logic step;       // counter advances this cycle
    logic toZero;     // next value is zero
    logic countDown;  // next value is count minus one
    logic ovfEvt;     // wrap event for the flag
  } cntStrobe_t;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_CNT   = 3'd1;
  localparam logic [REG_AW-1:0] A_PER   = 3'd2;
  localparam logic [REG_AW-1:0] A_C0CTL = 3'd3;
  localparam logic [REG_AW-1:0] A_C1VAL = 3'd4;
  localparam logic [REG_AW-1:0] A_C1CTL = 3'd5;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             clrReq,
  input  logic             cntWr,
  input  cntMode_t         cntMode,
  input  logic [1:0]       divSel,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  output cntStrobe_t       strobe
);
  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] preMask;
  logic tick;
  logic halted;
  logic downQ;
  logic atTop;

  // low divSel bits of the prescaler must all be ones for a step
  always_comb begin
    preMask = '0;
    for (int b = 0; b < PRE_W; b++) begin
      if (b < int'(divSel)) preMask[b] = 1'b1;
    end
  end

  assign tick   = clkEn && ((preQ & preMask) == preMask);
  assign halted = (cntMode == MODE_HALT) || ((cntMode != MODE_FREE) && (period == '0));
  assign atTop  = (cnt >= period);

  always_ff @(posedge clk) begin
    if (!rstN)       preQ <= '0;
    else if (clrReq) preQ <= '0;
    else if (clkEn)  preQ <= preQ + 1'b1;
  end

  always_comb begin
    strobe = '0;
    if (tick && !halted && !clrReq && !cntWr) begin
      strobe.step = 1'b1;
      unique case (cntMode)
        MODE_UP: begin
          if (atTop) begin
            strobe.toZero = 1'b1;
            strobe.ovfEvt = 1'b1;
          end
        end
        MODE_FREE: strobe.ovfEvt = &cnt;
        MODE_UPDN: begin
          if (downQ) begin
            strobe.countDown = (cnt != '0);
            strobe.ovfEvt    = (cnt == CNT_W'(1));
          end else if (atTop) begin
            strobe.countDown = 1'b1;
            strobe.ovfEvt    = (cnt == CNT_W'(1));
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) downQ <= 1'b0;
    else if (clrReq || cntMode != MODE_UPDN) downQ <= 1'b0;
    else if (strobe.step) begin
      if (!downQ && atTop && cnt > CNT_W'(1)) downQ <= 1'b1;
      else if (downQ && cnt <= CNT_W'(1))     downQ <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic [1:0]        capIn,
  input  cntStrobe_t        strobe,
  output cntMode_t          cntMode,
  output logic [1:0]        divSel,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  period,
  output logic              clrReq,
  output logic              cntWr,
  output logic              pwmOut,
  output logic              ovfFlag,
  output logic [1:0]        chFlag
);
  localparam int NCH = 2;

  cntMode_t         modeQ;
  logic [1:0]       divQ;
  logic             ovfQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] nextCnt;
  logic             ctrlWr;

  logic [CNT_W-1:0] chVal [NCH];
  logic [CNT_W-1:0] chCtl [NCH];
  logic [NCH-1:0]   matchEv;
  logic [NCH-1:0]   capSel;

  logic [2:0] outModeQ;
  logic       outBitQ;
  logic       outQ;
  logic       outNext;

  assign ctrlWr = wrEn && (regAddr == A_CTRL);
  assign clrReq = ctrlWr && wrData[4];
  assign cntWr  = wrEn && (regAddr == A_CNT);

  always_comb begin
    if (strobe.toZero)         nextCnt = '0;
    else if (strobe.countDown) nextCnt = cntQ - 1'b1;
    else                       nextCnt = cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_HALT;
      divQ  <= '0;
      ovfQ  <= 1'b0;
      cntQ  <= '0;
    end else begin
      if (ctrlWr) begin
        modeQ <= cntMode_t'(wrData[1:0]);
        divQ  <= wrData[3:2];
      end
      if (strobe.ovfEvt)  ovfQ <= 1'b1;
      else if (ctrlWr)    ovfQ <= wrData[5];
      if (clrReq)           cntQ <= '0;
      else if (cntWr)       cntQ <= wrData;
      else if (strobe.step) cntQ <= nextCnt;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : gCh
    localparam logic [REG_AW-1:0] VAL_A = REG_AW'(2 + 2 * i);
    localparam logic [REG_AW-1:0] CTL_A = REG_AW'(3 + 2 * i);

    logic [CNT_W-1:0]     valQ;
    logic                 capQ;
    logic [1:0]           edgeQ;
    logic                 flagQ;
    logic                 covfQ;
    logic                 pendQ;
    logic [SYNC_STAGES:0] syncQ;
    logic                 synced;
    logic                 prevLvl;
    logic                 capEv;
    logic                 valRead;
    logic                 ctlWr;

    assign synced  = syncQ[SYNC_STAGES-1];
    assign prevLvl = syncQ[SYNC_STAGES];
    assign capEv   = capQ && ((edgeQ[0] && synced && !prevLvl) ||
                              (edgeQ[1] && !synced && prevLvl));
    assign valRead = rdEn && (regAddr == VAL_A);
    assign ctlWr   = wrEn && (regAddr == CTL_A);
    assign matchEv[i] = strobe.step && (nextCnt == valQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        valQ  <= '0;
        capQ  <= 1'b0;
        edgeQ <= '0;
        flagQ <= 1'b0;
        covfQ <= 1'b0;
        pendQ <= 1'b0;
        syncQ <= '0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-1:0], capIn[i]};
        if (capEv)                             valQ <= cntQ;
        else if (wrEn && regAddr == VAL_A)     valQ <= wrData;
        if (ctlWr) begin
          capQ  <= wrData[0];
          edgeQ <= wrData[2:1];
        end
        if (capEv || (!capQ && matchEv[i]))    flagQ <= 1'b1;
        else if (ctlWr)                        flagQ <= wrData[3];
        if (capEv && pendQ && !valRead)        covfQ <= 1'b1;
        else if (ctlWr)                        covfQ <= wrData[4];
        if (capEv)                             pendQ <= 1'b1;
        else if (valRead)                      pendQ <= 1'b0;
      end
    end

    assign chVal[i]  = valQ;
    assign capSel[i] = capQ;
    assign chFlag[i] = flagQ;
    always_comb begin
      chCtl[i]      = '0;
      chCtl[i][0]   = capQ;
      chCtl[i][2:1] = edgeQ;
      chCtl[i][3]   = flagQ;
      chCtl[i][4]   = covfQ;
      chCtl[i][5]   = synced;
    end
  end

  // waveform unit on channel 1: channel action first, period action last
  always_comb begin
    outNext = outQ;
    if (matchEv[1] && !capSel[1]) begin
      unique case (outModeQ)
        3'd1, 3'd3:       outNext = 1'b1;
        3'd2, 3'd4, 3'd6: outNext = ~outQ;
        3'd5, 3'd7:       outNext = 1'b0;
        default: ;
      endcase
    end
    if (matchEv[0]) begin
      unique case (outModeQ)
        3'd2, 3'd3: outNext = 1'b0;
        3'd6, 3'd7: outNext = 1'b1;
        default: ;
      endcase
    end
    if (outModeQ == 3'd0) outNext = outBitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outModeQ <= '0;
      outBitQ  <= 1'b0;
      outQ     <= 1'b0;
    end else begin
      if (wrEn && regAddr == A_C1CTL) begin
        outModeQ <= wrData[8:6];
        outBitQ  <= wrData[9];
      end
      outQ <= outNext;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      A_CTRL: begin
        rdData[1:0] = modeQ;
        rdData[3:2] = divQ;
        rdData[5]   = ovfQ;
      end
      A_CNT:   rdData = cntQ;
      A_PER:   rdData = chVal[0];
      A_C0CTL: rdData = chCtl[0];
      A_C1VAL: rdData = chVal[1];
      A_C1CTL: begin
        rdData      = chCtl[1];
        rdData[8:6] = outModeQ;
        rdData[9]   = outBitQ;
      end
      default: rdData = '0;
    endcase
  end

  assign cntMode = modeQ;
  assign divSel  = divQ;
  assign cnt     = cntQ;
  assign period  = chVal[0];
  assign ovfFlag = ovfQ;
  assign pwmOut  = (outModeQ == 3'd0) ? outBitQ : outQ;
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic [1:0]        capIn,
  output logic              pwmOut,
  output logic              ovfFlag,
  output logic [1:0]        chFlag
);
  cntStrobe_t       strobe;
  cntMode_t         cntMode;
  logic [1:0]       divSel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic             clrReq;
  logic             cntWr;

  tmr_ctrl #(.CNT_W(CNT_W), .PRE_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .clrReq(clrReq), .cntWr(cntWr),
    .cntMode(cntMode), .divSel(divSel), .cnt(cnt), .period(period),
    .strobe(strobe)
  );

  tmr_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .capIn(capIn), .strobe(strobe),
    .cntMode(cntMode), .divSel(divSel), .cnt(cnt), .period(period),
    .clrReq(clrReq), .cntWr(cntWr), .pwmOut(pwmOut), .ovfFlag(ovfFlag),
    .chFlag(chFlag)
  );
endmodule

// File: rtl/mode_timer_chk.sv
module mode_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              wrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  period,
  input cntMode_t          cntMode,
  input cntStrobe_t        strobe,
  input logic              ovfFlag
);
  assert_step_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> clkEn);

  assert_halt_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == MODE_HALT && !(wrEn && (regAddr == A_CNT || regAddr == A_CTRL)))
      |=> $stable(cnt));

  assert_zero_period_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode != MODE_FREE && period == '0) |-> !strobe.step);

  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && cntMode == MODE_UP && cnt >= period) |=> (cnt == '0 && ovfFlag));

  assert_free_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && cntMode == MODE_FREE && (&cnt)) |=> (cnt == '0 && ovfFlag));

  assert_updn_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && cntMode == MODE_UPDN && cnt <= period && !wrEn)
      |=> (cnt <= period || period != $past(period)));
endmodule

bind mode_timer mode_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_mode_timer.sv
module sim_mode_timer;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  capIn = '0;
  logic        pwmOut;
  logic        ovfFlag;
  logic [1:0]  chFlag;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  mode_timer u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .rdEn(rdEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .capIn(capIn),
    .pwmOut(pwmOut), .ovfFlag(ovfFlag), .chFlag(chFlag)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic pulse(int n);
    if (n > 0) begin
      @(negedge clk);
      clkEn = 1'b1;
      repeat (n) @(negedge clk);
      clkEn = 1'b0;
    end
  endtask

  function automatic bit outStep(int m, bit o, bit chM, bit perM);
    bit r = o;
    if (chM) begin
      if (m == 1 || m == 3) r = 1'b1;
      else if (m == 2 || m == 4 || m == 6) r = ~r;
      else if (m == 5 || m == 7) r = 1'b0;
    end
    if (perM) begin
      if (m == 2 || m == 3) r = 1'b0;
      else if (m == 6 || m == 7) r = 1'b1;
    end
    return r;
  endfunction

  function automatic int updnCount(int k, int p);
    int r = k % (2 * p);
    return (r <= p) ? r : 2 * p - r;
  endfunction

  task automatic runOut(string tag, int m, bit b, int chv, int per, int n);
    bit exp;
    int c;
    wr(A_PER, 16'(per));
    wr(A_C1VAL, 16'(chv));
    wr(A_C1CTL, 16'(int'(b) << 9));
    wr(A_C1CTL, 16'(int'(b) << 9));
    wr(A_C1CTL, 16'((int'(b) << 9) | (m << 6)));
    wr(A_CTRL, 16'h0011);
    exp = b;
    c = 0;
    check(tag, 32'(pwmOut), 32'(exp));
    for (int k = 0; k < n; k++) begin
      pulse(1);
      c = (c >= per) ? 0 : c + 1;
      exp = outStep(m, exp, c == chv, c == per);
      check(tag, 32'(pwmOut), 32'(exp));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      peek(3'(a), d);
      check("R1 reset reg", 32'(d), 32'h0);
    end
    check("R1 reset pwm", 32'(pwmOut), 0);
    check("R1 reset flags", {29'd0, ovfFlag, chFlag}, 0);

    // R2 halt mode holds
    wr(A_CNT, 16'd5);
    pulse(10);
    peek(A_CNT, d);
    check("R2 halt", 32'(d), 32'd5);

    // R3 up mode directed
    wr(A_PER, 16'd4);
    wr(A_C0CTL, 16'h0);
    wr(A_CTRL, 16'h0011);
    pulse(4);
    peek(A_CNT, d);
    check("R3 up top", 32'(d), 32'd4);
    check("R3 period flag", 32'(chFlag[0]), 1);
    check("R3 no wrap yet", 32'(ovfFlag), 0);
    pulse(1);
    peek(A_CNT, d);
    check("R3 wrap count", 32'(d), 0);
    check("R3 wrap flag", 32'(ovfFlag), 1);

    // R3 up mode random
    for (int it = 0; it < 12; it++) begin
      int p = 1 + int'($urandom % 30);
      int k = int'($urandom % 100);
      wr(A_PER, 16'(p));
      wr(A_C0CTL, 16'h0);
      wr(A_CTRL, 16'h0011);
      pulse(k);
      peek(A_CNT, d);
      check("R3 up count", 32'(d), 32'(k % (p + 1)));
      check("R3 up wrap", 32'(ovfFlag), 32'(k > p));
      check("R3 up period flag", 32'(chFlag[0]), 32'(k >= p));
    end

    // R4 continuous wrap, R8 zero period does not stop it
    wr(A_PER, 16'd0);
    wr(A_CNT, 16'hFFFD);
    wr(A_CTRL, 16'h0002);
    pulse(2);
    peek(A_CNT, d);
    check("R4 free top", 32'(d), 32'hFFFF);
    check("R4 no wrap yet", 32'(ovfFlag), 0);
    pulse(1);
    peek(A_CNT, d);
    check("R4 R8 free wraps", 32'(d), 0);
    check("R4 wrap flag", 32'(ovfFlag), 1);
    for (int it = 0; it < 8; it++) begin
      int v = 16'hFFFF - int'($urandom % 40);
      int k = int'($urandom % 50);
      wr(A_CNT, 16'(v));
      wr(A_CTRL, 16'h0002);
      pulse(k);
      peek(A_CNT, d);
      check("R4 free count", 32'(d), 32'((v + k) % 65536));
      check("R4 free wrap", 32'(ovfFlag), 32'(v + k >= 65536));
    end

    // R5 up/down
    for (int it = 0; it < 12; it++) begin
      int p = (it < 2) ? it + 1 : 1 + int'($urandom % 20);
      int k = (it < 2) ? 3 * p : int'($urandom % 90);
      wr(A_PER, 16'(p));
      wr(A_C0CTL, 16'h0);
      wr(A_CTRL, 16'h0013);
      pulse(k);
      peek(A_CNT, d);
      check("R5 updn count", 32'(d), 32'(updnCount(k, p)));
      check("R5 updn wrap", 32'(ovfFlag), 32'(k >= 2 * p));
      check("R5 updn period flag", 32'(chFlag[0]), 32'(k >= p));
    end

    // R6 prescaler
    wr(A_PER, 16'd1000);
    for (int dv = 0; dv < 4; dv++) begin
      for (int it = 0; it < 3; it++) begin
        int n = int'($urandom % 40);
        wr(A_CTRL, 16'(16'h0011 | (dv << 2)));
        pulse(n);
        peek(A_CNT, d);
        check("R6 divide", 32'(d), 32'(n >> dv));
      end
    end

    // R7 clear zeroes prescaler, counter writes
    wr(A_CTRL, 16'h0019);
    pulse(3);
    wr(A_CTRL, 16'h0019);
    pulse(3);
    peek(A_CNT, d);
    check("R7 clear resets prescaler", 32'(d), 0);
    pulse(1);
    peek(A_CNT, d);
    check("R7 step after clear", 32'(d), 1);
    wr(A_CNT, 16'h0234);
    peek(A_CNT, d);
    check("R7 load", 32'(d), 32'h0234);
    wr(A_CNT, 16'h0);
    peek(A_CNT, d);
    check("R7 write zero", 32'(d), 0);
    wr(A_CNT, 16'h0007);
    wr(A_CTRL, 16'h0019);
    peek(A_CNT, d);
    check("R7 clear bit", 32'(d), 0);
    peek(A_CTRL, d);
    check("R7 clear reads zero", 32'(d), 32'h0009);

    // R8 zero period halts up and up/down
    wr(A_PER, 16'd0);
    wr(A_CNT, 16'd3);
    wr(A_CTRL, 16'h0001);
    pulse(5);
    peek(A_CNT, d);
    check("R8 up halted", 32'(d), 3);
    wr(A_CTRL, 16'h0003);
    pulse(5);
    peek(A_CNT, d);
    check("R8 updn halted", 32'(d), 3);

    // R9 capture edges, counter halted
    wr(A_CTRL, 16'h0000);
    wr(A_CNT, 16'h0042);
    wr(A_C1CTL, 16'h0003);
    @(negedge clk); capIn[1] = 1'b1;
    @(negedge clk);
    peek(A_C1CTL, d);
    check("R9 sync one clock", 32'(d[5]), 0);
    @(negedge clk);
    peek(A_C1CTL, d);
    check("R9 sync two clocks", 32'(d[5]), 1);
    repeat (3) @(negedge clk);
    rd(A_C1VAL, d);
    check("R9 rising capture", 32'(d), 32'h0042);
    check("R9 capture flag", 32'(chFlag[1]), 1);
    wr(A_C1CTL, 16'h0003);
    wr(A_CNT, 16'h0050);
    @(negedge clk); capIn[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_C1VAL, d);
    check("R9 falling ignored on 01", 32'(d), 32'h0042);
    check("R9 no flag on 01 fall", 32'(chFlag[1]), 0);
    wr(A_C1CTL, 16'h0005);
    @(negedge clk); capIn[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_C1VAL, d);
    check("R9 rising ignored on 10", 32'(d), 32'h0042);
    @(negedge clk); capIn[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_C1VAL, d);
    check("R9 falling capture", 32'(d), 32'h0050);
    wr(A_C1CTL, 16'h0001);
    wr(A_CNT, 16'h0061);
    @(negedge clk); capIn[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_C1VAL, d);
    check("R9 code 00 no capture", 32'(d), 32'h0050);
    check("R9 code 00 no flag", 32'(chFlag[1]), 0);
    wr(A_C1CTL, 16'h0007);
    @(negedge clk); capIn[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_C1VAL, d);
    check("R9 both fall", 32'(d), 32'h0061);
    wr(A_CNT, 16'h0072);
    @(negedge clk); capIn[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_C1VAL, d);
    check("R9 both rise", 32'(d), 32'h0072);

    // R10 capture overflow
    wr(A_C1CTL, 16'h0007);
    @(negedge clk); capIn[1] = 1'b0;
    repeat (5) @(negedge clk);
    @(negedge clk); capIn[1] = 1'b1;
    repeat (5) @(negedge clk);
    peek(A_C1CTL, d);
    check("R10 overflow set", 32'(d[4]), 1);
    wr(A_C1CTL, 16'h0007);
    rd(A_C1VAL, d);
    @(negedge clk); capIn[1] = 1'b0;
    repeat (5) @(negedge clk);
    peek(A_C1CTL, d);
    check("R10 no overflow after read", 32'(d[4]), 0);

    // R11 compare flag and software flag access
    wr(A_C1CTL, 16'h0000);
    wr(A_PER, 16'd10);
    wr(A_C1VAL, 16'd6);
    wr(A_CTRL, 16'h0011);
    pulse(5);
    check("R11 before match", 32'(chFlag[1]), 0);
    pulse(1);
    check("R11 match flag", 32'(chFlag[1]), 1);
    wr(A_C1CTL, 16'h0000);
    check("R11 sw clear", 32'(chFlag[1]), 0);
    wr(A_C1CTL, 16'h0008);
    check("R11 sw set", 32'(chFlag[1]), 1);
    wr(A_CTRL, 16'h0020);
    check("R11 sw wrap set", 32'(ovfFlag), 1);
    wr(A_CTRL, 16'h0000);
    check("R11 sw wrap clear", 32'(ovfFlag), 0);

    // R12 output mode 0
    wr(A_C1CTL, 16'h0200);
    check("R12 mode0 high", 32'(pwmOut), 1);
    wr(A_C1CTL, 16'h0000);
    check("R12 mode0 low", 32'(pwmOut), 0);

    // R12 output modes 1..7
    for (int m = 1; m < 8; m++) begin
      runOut("R12 waveform", m, 1'($urandom % 2), 4, 9, 22);
    end

    // R13 simultaneous channel and period match
    for (int m = 1; m < 8; m++) begin
      runOut("R13 same-step order", m, 1'(m % 2), 5, 5, 14);
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule